// File: doc/BRIEF.md
# Trimmed Seconds Divider

This block turns a free-running 32.768 kHz oscillator clock into a one-cycle pulse per second, plus a pulse at the close of every minute. It can nudge the long-term rate up or down in fine signed steps. The trim is applied by changing the length of a single second in some minutes. The minutes are counted inside a repeating window of 64 minutes, and a magnitude N selects the first 2N minutes of that window for adjustment. A positive sign makes those seconds shorter, so the clock gains. A negative sign makes them longer, so the clock loses.

Inside each adjusted minute, only the first second changes length. The magnitude and sign are captured once, when a window starts, so software can write a new value at any time without breaking the window that is running. A separate test enable drives out a square wave at one 64th of the nominal tick rate (512 Hz at the default rate). Its rate does not depend on the trim, so it can be used to measure the raw oscillator error before a trim value is chosen.

Every count is a parameter: the ticks per second, the seconds per minute, both trim amounts and the test half-period. A reduced configuration therefore behaves in exactly the same way at a smaller scale.

Top module: `rtc_cal_divider`

## Requirements
- R1: While reset is asserted, and after it is released, sec_tick, min_tick and test_wave are low. The captured trim value resets to zero, so the first 64-minute window after reset runs untrimmed whatever the inputs are.
- R2: With a captured magnitude of zero, every second lasts exactly TICKS_PER_SEC clock cycles, measured from one sec_tick pulse to the next, and each sec_tick pulse is one cycle wide.
- R3: min_tick pulses for one cycle in the same cycle as every SEC_PER_MIN-th sec_tick pulse (the last second of each minute), and at no other time.
- R4: With cal_pos = 1, an adjusted second lasts TICKS_PER_SEC - FAST_TRIM cycles.
- R5: With cal_pos = 0, an adjusted second lasts TICKS_PER_SEC + SLOW_TRIM cycles.
- R6: A captured magnitude N (cal_mag, unsigned, 0 to 31) adjusts minutes 0 to 2N-1 of the 64-minute window. Minutes from 2N to 63 run untrimmed, so minutes 62 and 63 are never adjusted.
- R7: Within an adjusted minute, only second 0 is changed. Every other second of that minute lasts TICKS_PER_SEC cycles.
- R8: cal_mag and cal_pos are captured when the last second of minute 63 ends. A value changed in the middle of a window takes effect only from minute 0 of the next window.
- R9: While test_en is high, test_wave toggles every TEST_HALF cycles whatever the trim is. While test_en is low, test_wave is held low.
- R10: Over a whole window, the total length is 64 × SEC_PER_MIN × TICKS_PER_SEC, minus 2N × FAST_TRIM for a positive trim or plus 2N × SLOW_TRIM for a negative trim.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| osc_clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cal_mag | input | 5 | Trim magnitude N (number of adjusted minute pairs) |
| cal_pos | input | 1 | Trim sign: 1 shortens (gain), 0 lengthens (lose) |
| test_en | input | 1 | Enables the fixed-rate test square wave |
| sec_tick | output | 1 | One-cycle pulse at the end of each second |
| min_tick | output | 1 | One-cycle pulse at the end of each minute |
| test_wave | output | 1 | Untrimmed test square wave, low when disabled |

## Verification
The bench runs the block in a reduced configuration through four windows in a row, and the length of every second is logged. The first window stays untrimmed even though a value is written mid-window, which separates capture at the window start from capture at once. The second window uses a small positive magnitude and the third a single negative step, so shortening is told apart from lengthening and the minute boundary 2N is located. The last window uses the largest magnitude, which shows that minutes 62 and 63 stay untouched and that only second 0 of a minute moves. The test wave is measured during a trimmed window to show that its rate does not depend on the trim.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
    // Kind of adjustment applied to the second currently being counted
    typedef enum logic [1:0] {
        TRIM_NONE = 2'd0,
        TRIM_FAST = 2'd1,
        TRIM_SLOW = 2'd2
    } trim_e;
endpackage

// File: rtl/cal_prescaler.sv
module cal_prescaler
    import rtc_cal_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768,
    parameter int FAST_TRIM     = 256,
    parameter int SLOW_TRIM     = 128
) (
    input  logic  clk,
    input  logic  rst_n,
    input  trim_e trim,
    output logic  wrap,
    output logic  sec_tick
);
    localparam int CNT_W = $clog2(TICKS_PER_SEC + SLOW_TRIM);
    localparam logic [CNT_W-1:0] TERM_NOM  = CNT_W'(TICKS_PER_SEC - 1);
    localparam logic [CNT_W-1:0] TERM_FAST = CNT_W'(TICKS_PER_SEC - FAST_TRIM - 1);
    localparam logic [CNT_W-1:0] TERM_SLOW = CNT_W'(TICKS_PER_SEC + SLOW_TRIM - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             tick;
    } pre_t;

    pre_t             st_d, st_q;
    logic [CNT_W-1:0] term;

    always_comb begin
        case (trim)
            TRIM_FAST: term = TERM_FAST;
            TRIM_SLOW: term = TERM_SLOW;
            default:   term = TERM_NOM;
        endcase
        wrap      = (st_q.cnt == term);
        st_d      = st_q;
        st_d.tick = wrap;
        if (wrap) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sec_tick = st_q.tick;
endmodule

// File: rtl/cal_sequencer.sv
module cal_sequencer
    import rtc_cal_pkg::*;
#(
    parameter int SEC_PER_MIN = 60,
    parameter int MAG_W       = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wrap,
    input  logic [MAG_W-1:0] cal_mag,
    input  logic             cal_pos,
    output trim_e            trim,
    output logic             min_tick
);
    // The window holds 2^(MAG_W+1) minutes, 64 by default
    localparam int MIN_W = MAG_W + 1;
    localparam int SEC_W = (SEC_PER_MIN > 1) ? $clog2(SEC_PER_MIN) : 1;
    localparam logic [SEC_W-1:0] SEC_LAST = SEC_W'(SEC_PER_MIN - 1);
    localparam logic [MIN_W-1:0] MIN_LAST = '1;

    typedef struct packed {
        logic [SEC_W-1:0] sec_idx;
        logic [MIN_W-1:0] min_idx;
        logic [MAG_W-1:0] mag;
        logic             pos;
        logic             mtick;
    } seq_t;

    seq_t st_d, st_q;
    logic end_of_min;
    logic in_window;

    always_comb begin
        end_of_min = wrap && (st_q.sec_idx == SEC_LAST);
        st_d       = st_q;
        st_d.mtick = end_of_min;
        if (wrap) begin
            if (end_of_min) begin
                st_d.sec_idx = '0;
                st_d.min_idx = st_q.min_idx + 1'b1;
                if (st_q.min_idx == MIN_LAST) begin
                    st_d.mag = cal_mag;
                    st_d.pos = cal_pos;
                end
            end else begin
                st_d.sec_idx = st_q.sec_idx + 1'b1;
            end
        end
        in_window = (st_q.min_idx < {st_q.mag, 1'b0});
        if ((st_q.sec_idx == '0) && in_window) begin
            trim = st_q.pos ? TRIM_FAST : TRIM_SLOW;
        end else begin
            trim = TRIM_NONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign min_tick = st_q.mtick;
endmodule

// File: rtl/cal_test_wave.sv
module cal_test_wave #(
    parameter int TEST_HALF = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic test_en,
    output logic wave
);
    localparam int HW = $clog2(TEST_HALF + 1);
    localparam logic [HW-1:0] HALF_LAST = HW'(TEST_HALF - 1);

    typedef struct packed {
        logic [HW-1:0] cnt;
        logic          wave;
    } tw_t;

    tw_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!test_en) begin
            st_d = '0;
        end else if (st_q.cnt == HALF_LAST) begin
            st_d.cnt  = '0;
            st_d.wave = ~st_q.wave;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wave = st_q.wave;
endmodule

// File: rtl/rtc_cal_divider.sv
module rtc_cal_divider
    import rtc_cal_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768,
    parameter int SEC_PER_MIN   = 60,
    parameter int FAST_TRIM     = 256,
    parameter int SLOW_TRIM     = 128,
    parameter int TEST_HALF     = 32
) (
    input  logic       osc_clk,
    input  logic       rst_n,
    input  logic [4:0] cal_mag,
    input  logic       cal_pos,
    input  logic       test_en,
    output logic       sec_tick,
    output logic       min_tick,
    output logic       test_wave
);
    trim_e trim;
    logic  wrap;

    cal_prescaler #(
        .TICKS_PER_SEC(TICKS_PER_SEC),
        .FAST_TRIM    (FAST_TRIM),
        .SLOW_TRIM    (SLOW_TRIM)
    ) u_pre (
        .clk     (osc_clk),
        .rst_n   (rst_n),
        .trim    (trim),
        .wrap    (wrap),
        .sec_tick(sec_tick)
    );

    cal_sequencer #(
        .SEC_PER_MIN(SEC_PER_MIN),
        .MAG_W      (5)
    ) u_seq (
        .clk     (osc_clk),
        .rst_n   (rst_n),
        .wrap    (wrap),
        .cal_mag (cal_mag),
        .cal_pos (cal_pos),
        .trim    (trim),
        .min_tick(min_tick)
    );

    cal_test_wave #(
        .TEST_HALF(TEST_HALF)
    ) u_tw (
        .clk    (osc_clk),
        .rst_n  (rst_n),
        .test_en(test_en),
        .wave   (test_wave)
    );
endmodule

// File: rtl/rtc_cal_divider_chk.sv
module rtc_cal_divider_chk #(
    parameter int TICKS_PER_SEC = 32768,
    parameter int FAST_TRIM     = 256,
    parameter int SLOW_TRIM     = 128
) (
    input logic osc_clk,
    input logic rst_n,
    input logic test_en,
    input logic sec_tick,
    input logic min_tick,
    input logic test_wave
);
    logic [31:0] gap_q;
    logic        seen_q;

    always_ff @(posedge osc_clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q  <= 32'd0;
            seen_q <= 1'b0;
        end else if (sec_tick) begin
            gap_q  <= 32'd1;
            seen_q <= 1'b1;
        end else begin
            gap_q  <= gap_q + 32'd1;
        end
    end

    AST_SEC_PULSE_WIDTH: assert property (@(posedge osc_clk) disable iff (!rst_n)
        sec_tick |=> !sec_tick); // R2

    AST_MIN_WITH_SEC: assert property (@(posedge osc_clk) disable iff (!rst_n)
        min_tick |-> sec_tick); // R3

    AST_SEC_LENGTH_LEGAL: assert property (@(posedge osc_clk) disable iff (!rst_n)
        (sec_tick && seen_q) |-> ((gap_q == 32'(TICKS_PER_SEC)) ||
                                  (gap_q == 32'(TICKS_PER_SEC - FAST_TRIM)) ||
                                  (gap_q == 32'(TICKS_PER_SEC + SLOW_TRIM)))); // R4

    AST_TEST_IDLE_LOW: assert property (@(posedge osc_clk) disable iff (!rst_n)
        !test_en |=> !test_wave); // R9
endmodule

bind rtc_cal_divider rtc_cal_divider_chk #(
    .TICKS_PER_SEC(TICKS_PER_SEC),
    .FAST_TRIM    (FAST_TRIM),
    .SLOW_TRIM    (SLOW_TRIM)
) u_chk (
    .osc_clk  (osc_clk),
    .rst_n    (rst_n),
    .test_en  (test_en),
    .sec_tick (sec_tick),
    .min_tick (min_tick),
    .test_wave(test_wave)
);

// File: tb/tb_rtc_cal_divider.sv
module tb_rtc_cal_divider;
    localparam int TPS   = 64;
    localparam int SPM   = 4;
    localparam int FAST  = 8;
    localparam int SLOW  = 4;
    localparam int HALF  = 4;
    localparam int SPW   = SPM * 64;
    localparam int NSEC  = SPW * 4;

    logic       osc_clk = 1'b0;
    logic       rst_n   = 1'b0;
    logic [4:0] cal_mag = 5'd0;
    logic       cal_pos = 1'b0;
    logic       test_en = 1'b0;
    logic       sec_tick, min_tick, test_wave;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int nsec = 0;
    int last_t = 0;
    int min_err = 0;
    int min_seen = 0;
    int len_log [NSEC];
    bit done = 1'b0;

    always #2 osc_clk = ~osc_clk;

    rtc_cal_divider #(
        .TICKS_PER_SEC(TPS),
        .SEC_PER_MIN  (SPM),
        .FAST_TRIM    (FAST),
        .SLOW_TRIM    (SLOW),
        .TEST_HALF    (HALF)
    ) dut (
        .osc_clk  (osc_clk),
        .rst_n    (rst_n),
        .cal_mag  (cal_mag),
        .cal_pos  (cal_pos),
        .test_en  (test_en),
        .sec_tick (sec_tick),
        .min_tick (min_tick),
        .test_wave(test_wave)
    );

    // Logs the length of each second and checks minute-pulse alignment
    always @(negedge osc_clk) begin
        if (rst_n) begin
            cyc = cyc + 1;
            if (sec_tick) begin
                if (nsec < NSEC) len_log[nsec] = cyc - last_t;
                last_t = cyc;
                if ((nsec % SPM) == SPM - 1) begin
                    if (!min_tick) min_err = min_err + 1;
                    else min_seen = min_seen + 1;
                end else if (min_tick) begin
                    min_err = min_err + 1;
                end
                nsec = nsec + 1;
            end else if (min_tick) begin
                min_err = min_err + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            failures = failures + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected second length from the requirements (R4, R5, R6, R7)
    function automatic int exp_len(input int k, input int mag, input bit pos);
        int mn = (k / SPM) % 64;
        int sc = k % SPM;
        if (sc == 0 && mn < 2 * mag) return pos ? TPS - FAST : TPS + SLOW;
        return TPS;
    endfunction

    task automatic check_window(input int w, input int mag, input bit pos, input string req);
        int sum = 0;
        for (int k = w * SPW; k < (w + 1) * SPW; k++) begin
            if (k > 0) chk(len_log[k] == exp_len(k, mag, pos), req, len_log[k], exp_len(k, mag, pos));
            sum = sum + len_log[k];
        end
        if (w > 0) begin
            int e = SPW * TPS + (pos ? -(2 * mag * FAST) : (2 * mag * SLOW));
            chk(sum == e, "R10 window total", sum, e);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (5) @(negedge osc_clk);
        chk(sec_tick == 1'b0, "R1 sec_tick in reset", int'(sec_tick), 0);
        chk(min_tick == 1'b0, "R1 min_tick in reset", int'(min_tick), 0);
        chk(test_wave == 1'b0, "R1 test_wave in reset", int'(test_wave), 0);
        cal_mag = 5'd7;
        cal_pos = 1'b1;
        rst_n = 1'b1;
        @(negedge osc_clk);
        chk(sec_tick == 1'b0, "R1 sec_tick after reset", int'(sec_tick), 0);
        // test_en low: wave must stay low for several half-periods (R9)
        repeat (3 * HALF) @(negedge osc_clk);
        chk(test_wave == 1'b0, "R9 wave held low when disabled", int'(test_wave), 0);
    endtask

    task automatic t_first_window();
        wait (nsec >= 100);
        cal_mag = 5'd2;
        cal_pos = 1'b1;
        wait (nsec >= SPW);
        // R1/R2/R8: window 0 untrimmed despite inputs set during it
        check_window(0, 0, 1'b0, "R8 R2 untrimmed first window");
    endtask

    task automatic t_positive_window();
        wait (nsec >= SPW + 44);
        cal_mag = 5'd1;
        cal_pos = 1'b0;
        wait (nsec >= 2 * SPW);
        check_window(1, 2, 1'b1, "R4 R6 R7 positive N=2");
        chk(len_log[SPW + 4 * SPM] == TPS, "R6 minute 2N nominal", len_log[SPW + 4 * SPM], TPS);
        chk(len_log[SPW + 1] == TPS, "R7 second 1 nominal", len_log[SPW + 1], TPS);
    endtask

    task automatic t_negative_window();
        wait (nsec >= 2 * SPW + 88);
        cal_mag = 5'd31;
        cal_pos = 1'b1;
        wait (nsec >= 3 * SPW);
        check_window(2, 1, 1'b0, "R5 R6 negative N=1");
        chk(len_log[2 * SPW] == TPS + SLOW, "R5 lengthened second", len_log[2 * SPW], TPS + SLOW);
    endtask

    task automatic t_test_wave();
        int last_c = 0;
        int ntog = 0;
        logic prev;
        wait (nsec >= 3 * SPW + 2);
        @(negedge osc_clk);
        test_en = 1'b1;
        prev = test_wave;
        for (int i = 0; i < 20 * HALF; i++) begin
            @(negedge osc_clk);
            if (test_wave !== prev) begin
                if (ntog > 0) chk(cyc - last_c == HALF, "R9 test half-period", cyc - last_c, HALF);
                last_c = cyc;
                ntog = ntog + 1;
                prev = test_wave;
            end
        end
        chk(ntog >= 18, "R9 test toggles present", ntog, 20);
        test_en = 1'b0;
        repeat (2) @(negedge osc_clk);
        chk(test_wave == 1'b0, "R9 wave low after disable", int'(test_wave), 0);
    endtask

    task automatic t_full_window();
        wait (nsec >= 4 * SPW);
        check_window(3, 31, 1'b1, "R6 R7 positive N=31");
        chk(len_log[3 * SPW + 62 * SPM] == TPS, "R6 minute 62 untouched", len_log[3 * SPW + 62 * SPM], TPS);
        chk(len_log[3 * SPW + 63 * SPM] == TPS, "R6 minute 63 untouched", len_log[3 * SPW + 63 * SPM], TPS);
        chk(len_log[3 * SPW + 61 * SPM] == TPS - FAST, "R4 minute 61 shortened", len_log[3 * SPW + 61 * SPM], TPS - FAST);
    endtask

    task automatic t_minute();
        chk(min_err == 0, "R3 min_tick misaligned", min_err, 0);
        chk(min_seen == NSEC / SPM, "R3 min_tick count", min_seen, NSEC / SPM);
    endtask

    initial begin
        t_reset();
        t_first_window();
        t_positive_window();
        t_negative_window();
        t_test_wave();
        t_full_window();
        t_minute();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge osc_clk);
        if (!done) begin
            checks = checks + 1;
            failures = failures + 1;
            $display("FAIL watchdog actual=%0d expected=%0d", nsec, NSEC);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule